// File: doc/BRIEF.md
# Bit-Serial Chained Maximum Stage

This block is one node's stage in a ring of nodes that together find the largest of their unsigned numbers in a single serial pass. Every stage sees three serial lines. The first is the stream arriving from the previous stage, which carries the largest value found so far. The second is the node's own number. The third is a synchronization stream that marks where each number begins. Bits travel most significant first. The stage emits the larger of the two numbers bit by bit and passes the synchronization stream on to the next stage. Every line is two-rail coded: for each logical wire, a pulse on rail 1 means a 1 and a pulse on rail 0 means a 0.

The stage decides the comparison on the fly. A three-valued state register starts each number in `CMP_EQ`. At the first bit position where the two numbers differ, it moves to `CMP_IN_WINS` or `CMP_LOC_WINS` and stays there until the next synchronization pulse. The output selector then tracks the winning stream. Because of this, the maximum leaves the stage after one register of delay and the whole number is never buffered.

The transitions are:
- `CMP_EQ` stays in `CMP_EQ` while the bits match.
- `CMP_EQ` goes to `CMP_IN_WINS` when the incoming bit is 1 and the local bit is 0.
- `CMP_EQ` goes to `CMP_LOC_WINS` in the opposite case.
- Either deciding state holds until a sync bit of 1.
- A sync bit of 1 evaluates the current bit as if the state were `CMP_EQ`.
- An idle or malformed cycle holds any state.

Top module: `serial_max_stage`

## Requirements
- R1: While reset is asserted and after it until the first symbol, all four output rails are 0, `code_err` is 0 and the comparison state is `CMP_EQ`.
- R2: For a valid symbol cycle, the output pair one clock later carries bit i of max(incoming, local), where bit i is the i-th bit MSB-first of the slot. Rail 1 high means 1 and rail 0 high means 0.
- R3: At the first differing bit, the larger stream's bit is emitted. After that, until the next sync pulse, the output follows only the winning stream: the local bits once the local number is larger, or the incoming bits once the incoming number is larger.
- R4: When the two numbers in a slot are equal, the output equals that common value.
- R5: A sync bit of 1 restarts the comparison, so each slot's winner is independent of the previous slot's outcome.
- R6: Each valid symbol's sync bit appears unchanged on the sync output rails one clock later.
- R7: A pair is valid when exactly one rail is high (01 on {rail1,rail0} = 0, 10 = 1). The output pairs use the same code, and no output pair ever has both rails high.
- R8: A cycle with all three input pairs at 00 is idle. Outputs are 00 one clock later, `code_err` is 0 and the state is held.
- R9: Any other non-symbol cycle (a pair at 11, or some pairs 00 while others are valid) raises `code_err` one clock later. In that cycle the outputs are 00 and the comparison state is held.
- R10: Latency is one clock for every bit position of the slot. Sync pulses arrive every `SLOT_W` valid symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_r0 | input | 1 | Incoming running-maximum stream, rail 0 |
| in_r1 | input | 1 | Incoming running-maximum stream, rail 1 |
| loc_r0 | input | 1 | Local number stream, rail 0 |
| loc_r1 | input | 1 | Local number stream, rail 1 |
| syn_r0 | input | 1 | Synchronization stream, rail 0 |
| syn_r1 | input | 1 | Synchronization stream, rail 1 |
| out_r0 | output | 1 | Maximum stream to next stage, rail 0 |
| out_r1 | output | 1 | Maximum stream to next stage, rail 1 |
| syn_out_r0 | output | 1 | Forwarded sync, rail 0 |
| syn_out_r1 | output | 1 | Forwarded sync, rail 1 |
| code_err | output | 1 | Malformed two-rail input seen in the previous cycle |

## Verification
Every result of this stage is due exactly one clock after the symbol that caused it: the maximum bit, the forwarded sync bit, the error flag and the null output for idle or malformed cycles. The bench drives each symbol just after a falling edge and samples all outputs at the next falling edge, after the single rising edge that registers them. Idle and malformed cycles are inserted inside slots. The bits that follow them must still match the reference maximum computed by the bench, which shows that the state was held across the gap.

// File: rtl/smax_pkg.sv
package smax_pkg;
    typedef enum logic [1:0] {
        CMP_EQ       = 2'd0,
        CMP_IN_WINS  = 2'd1,
        CMP_LOC_WINS = 2'd2
    } cmp_state_e;
endpackage

// File: rtl/rail_pair_decode.sv
module rail_pair_decode (
    input  logic [1:0] rails,   // {rail1, rail0}
    output logic       valid,
    output logic       null_c,
    output logic       value
);
    always_comb begin
        valid  = rails[0] ^ rails[1];
        null_c = ~(rails[0] | rails[1]);
        value  = rails[1];
    end
endmodule

// File: rtl/slot_position_track.sv
module slot_position_track #(
    parameter int SLOT_W = 8
) (
    input logic clk,
    input logic rst_n,
    input logic sym_ok,
    input logic sync_bit
);
    localparam int PW = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;
    localparam logic [PW-1:0] LAST = PW'(SLOT_W - 1);

    logic [PW-1:0] pos_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
        end else if (sym_ok) begin
            seen_q <= 1'b1;
            if (sync_bit) pos_q <= (SLOT_W > 1) ? PW'(1) : '0;
            else          pos_q <= (pos_q == LAST) ? '0 : pos_q + PW'(1);
        end
    end

    // R10: a sync pulse only at the start of each SLOT_W-symbol slot
    a_r10_sync_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_ok && seen_q) |-> (sync_bit == (pos_q == '0)));
endmodule

// File: rtl/max_compare_fsm.sv
module max_compare_fsm
    import smax_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sym_ok,
    input  logic sym_bad,
    input  logic in_bit,
    input  logic loc_bit,
    input  logic sync_bit,
    output logic out_vld_q,
    output logic out_bit_q,
    output logic sync_q,
    output logic err_q
);
    cmp_state_e state_q, state_d, base;
    logic       sel_bit;

    always_comb begin
        base    = sync_bit ? CMP_EQ : state_q;
        state_d = state_q;
        sel_bit = in_bit | loc_bit;
        if (sym_ok) begin
            unique case (base)
                CMP_EQ: begin
                    sel_bit = in_bit | loc_bit;
                    if (in_bit && !loc_bit)      state_d = CMP_IN_WINS;
                    else if (!in_bit && loc_bit) state_d = CMP_LOC_WINS;
                    else                         state_d = CMP_EQ;
                end
                CMP_IN_WINS: begin
                    sel_bit = in_bit;
                    state_d = CMP_IN_WINS;
                end
                CMP_LOC_WINS: begin
                    sel_bit = loc_bit;
                    state_d = CMP_LOC_WINS;
                end
                default: begin
                    sel_bit = in_bit | loc_bit;
                    state_d = CMP_EQ;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CMP_EQ;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_q <= 1'b0;
            out_bit_q <= 1'b0;
            sync_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            out_vld_q <= sym_ok;
            out_bit_q <= sym_ok & sel_bit;
            sync_q    <= sym_ok & sync_bit;
            err_q     <= sym_bad;
        end
    end

    // R8, R9: no symbol means the comparison state is held
    a_r9_hold_on_gap: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_ok |=> state_q == $past(state_q));
    // R3: a decided state is sticky until the next sync pulse
    a_r3_decided_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_ok && !sync_bit && state_q != CMP_EQ) |=> state_q == $past(state_q));
    // R3: after the local number wins, the output follows the local bits
    a_r3_follow_local: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_ok && !sync_bit && state_q == CMP_LOC_WINS) |=> out_bit_q == $past(loc_bit));
    // R5: a sync pulse with matching bits leaves the comparison open
    a_r5_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_ok && sync_bit && (in_bit == loc_bit)) |=> state_q == CMP_EQ);
endmodule

// File: rtl/serial_max_stage.sv
module serial_max_stage #(
    parameter int SLOT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_r0,
    input  logic in_r1,
    input  logic loc_r0,
    input  logic loc_r1,
    input  logic syn_r0,
    input  logic syn_r1,
    output logic out_r0,
    output logic out_r1,
    output logic syn_out_r0,
    output logic syn_out_r1,
    output logic code_err
);
    localparam int NPAIR = 3;   // 0: incoming, 1: local, 2: sync

    logic [1:0]       pair_rails [NPAIR];
    logic [NPAIR-1:0] pair_ok, pair_null, pair_val;
    logic             sym_ok, sym_bad;
    logic             out_vld_q, out_bit_q, sync_q, err_q;

    always_comb begin
        pair_rails[0] = {in_r1, in_r0};
        pair_rails[1] = {loc_r1, loc_r0};
        pair_rails[2] = {syn_r1, syn_r0};
    end

    for (genvar g = 0; g < NPAIR; g++) begin : g_dec
        rail_pair_decode u_dec (
            .rails  (pair_rails[g]),
            .valid  (pair_ok[g]),
            .null_c (pair_null[g]),
            .value  (pair_val[g])
        );
    end

    always_comb begin
        sym_ok  = &pair_ok;
        sym_bad = !sym_ok && !(&pair_null);
    end

    max_compare_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_ok    (sym_ok),
        .sym_bad   (sym_bad),
        .in_bit    (pair_val[0]),
        .loc_bit   (pair_val[1]),
        .sync_bit  (pair_val[2]),
        .out_vld_q (out_vld_q),
        .out_bit_q (out_bit_q),
        .sync_q    (sync_q),
        .err_q     (err_q)
    );

    slot_position_track #(.SLOT_W(SLOT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_ok   (sym_ok),
        .sync_bit (pair_val[2])
    );

    always_comb begin
        out_r1     = out_vld_q & out_bit_q;
        out_r0     = out_vld_q & ~out_bit_q;
        syn_out_r1 = out_vld_q & sync_q;
        syn_out_r0 = out_vld_q & ~sync_q;
        code_err   = err_q;
    end

    // R6: sync forwarded unchanged one clock later
    a_r6_sync_forward: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ok |=> ({syn_out_r1, syn_out_r0} == $past({syn_r1, syn_r0})));
    // R9: malformed input gives an error and null outputs
    a_r9_err_null: assert property (@(posedge clk) disable iff (!rst_n)
        sym_bad |=> (code_err && !out_r0 && !out_r1 && !syn_out_r0 && !syn_out_r1));
    // R8: idle gives null outputs and no error
    a_r8_idle_null: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_ok && !sym_bad) |=> (!code_err && !out_r0 && !out_r1));
    // R7: an output pair never has both rails high
    a_r7_out_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_r1, out_r0}) && $onehot0({syn_out_r1, syn_out_r0}));
    // R2: a valid symbol always yields a valid output pair
    a_r2_out_valid: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ok |=> $countones({out_r1, out_r0}) == 1);
endmodule

// File: tb/serial_max_stage_tb_top.sv
`timescale 1ns/1ps
module serial_max_stage_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_r0 = 0, in_r1 = 0, loc_r0 = 0, loc_r1 = 0, syn_r0 = 0, syn_r1 = 0;
    logic out_r0, out_r1, syn_out_r0, syn_out_r1, code_err;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #2.5 clk = ~clk;

    serial_max_stage #(.SLOT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_r0(in_r0), .in_r1(in_r1), .loc_r0(loc_r0), .loc_r1(loc_r1),
        .syn_r0(syn_r0), .syn_r1(syn_r1),
        .out_r0(out_r0), .out_r1(out_r1),
        .syn_out_r0(syn_out_r0), .syn_out_r1(syn_out_r1),
        .code_err(code_err)
    );

    function automatic logic [1:0] enc(input bit b);
        return b ? 2'b10 : 2'b01;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] pi, input logic [1:0] pl, input logic [1:0] ps);
        {in_r1, in_r0}   = pi;
        {loc_r1, loc_r0} = pl;
        {syn_r1, syn_r0} = ps;
    endtask

    // gap_pair: 0..2 = that pair gets gap_code, 3 = all pairs null (idle)
    task automatic send_slot(input logic [W-1:0] a, input logic [W-1:0] b,
                             input int gap_pos, input int gap_pair,
                             input logic [1:0] gap_code, input string req);
        logic [W-1:0] mx;
        mx = (a > b) ? a : b;
        for (int i = 0; i < W; i++) begin
            if (i == gap_pos) begin
                if (gap_pair == 3) begin
                    drive(2'b00, 2'b00, 2'b00);
                end else begin
                    drive(gap_pair == 0 ? gap_code : enc(a[W-1-i]),
                          gap_pair == 1 ? gap_code : enc(b[W-1-i]),
                          gap_pair == 2 ? gap_code : enc(i == 0));
                end
                @(negedge clk);
                chk(gap_pair == 3 ? "R8" : "R9", "err flag", int'(code_err), gap_pair == 3 ? 0 : 1);
                chk(gap_pair == 3 ? "R8" : "R9", "null out", int'({out_r1, out_r0, syn_out_r1, syn_out_r0}), 0);
            end
            drive(enc(a[W-1-i]), enc(b[W-1-i]), enc(i == 0));
            @(negedge clk);
            chk(req, "max bit", int'({out_r1, out_r0}), int'(enc(mx[W-1-i])));
            chk("R6", "sync fwd", int'({syn_out_r1, syn_out_r0}), int'(enc(i == 0)));
            chk("R9", "no err", int'(code_err), 0);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5eed_0042);
        drive(2'b00, 2'b00, 2'b00);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "outs in reset", int'({out_r1, out_r0, syn_out_r1, syn_out_r0}), 0);
        chk("R1", "err in reset", int'(code_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "outs after reset", int'({out_r1, out_r0, syn_out_r1, syn_out_r0}), 0);
        chk("R1", "err after reset", int'(code_err), 0);

        // R2, R7, R10: directed patterns
        send_slot(8'hA5, 8'h3C, -1, 0, 2'b00, "R2");
        send_slot(8'h00, 8'hFF, -1, 0, 2'b00, "R7");
        // R3: decision at the LSB and at the MSB
        send_slot(8'h80, 8'h81, -1, 0, 2'b00, "R3");
        send_slot(8'h7F, 8'h80, -1, 0, 2'b00, "R3");
        send_slot(8'hF0, 8'h0F, -1, 0, 2'b00, "R3");
        // R4: equal numbers
        send_slot(8'h5A, 8'h5A, -1, 0, 2'b00, "R4");
        send_slot(8'h00, 8'h00, -1, 0, 2'b00, "R4");
        send_slot(8'hFF, 8'hFF, -1, 0, 2'b00, "R4");
        // R5: back-to-back slots with opposite winners
        send_slot(8'h01, 8'hC0, -1, 0, 2'b00, "R5");
        send_slot(8'hC0, 8'h01, -1, 0, 2'b00, "R5");
        send_slot(8'h40, 8'h3F, -1, 0, 2'b00, "R5");
        // R8: idle inside a slot, before and after the deciding bit
        send_slot(8'h96, 8'h92, 4, 3, 2'b00, "R8");
        send_slot(8'h12, 8'h14, 6, 3, 2'b00, "R8");
        // R9: malformed codes inside a slot and at the sync bit
        send_slot(8'h3C, 8'h3D, 5, 0, 2'b11, "R9");
        send_slot(8'h81, 8'h7E, 1, 1, 2'b00, "R9");
        send_slot(8'h81, 8'h7E, 0, 2, 2'b11, "R9");

        // R10: random slots with fixed seed, one-clock latency at every position
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] a, b;
            int gp, gpair;
            logic [1:0] gcode;
            a = W'($urandom);
            case ($urandom % 4)
                0: b = a;
                1: b = a ^ W'(1);
                default: b = W'($urandom);
            endcase
            gp    = (($urandom % 4) == 0) ? int'($urandom % W) : -1;
            gpair = int'($urandom % 4);
            gcode = (($urandom % 2) == 0) ? 2'b11 : 2'b00;
            send_slot(a, b, gp, gpair, gcode, "R10");
        end

        // R8: trailing idle returns outputs to null
        drive(2'b00, 2'b00, 2'b00);
        @(negedge clk);
        chk("R8", "idle out", int'({out_r1, out_r0, syn_out_r1, syn_out_r0}), 0);
        chk("R8", "idle err", int'(code_err), 0);
        finish_run();
    end
endmodule